// File: doc/BRIEF.md
# Dual-Port RAM with Contention Arbitration

This block is a 1024-word by 8-bit memory shared by two symmetric ports, called left and right. Each port has its own enable, write select, output enable, address, write data and registered read data, so two agents can use the array in the same cycle without coordinating.

When both ports are enabled on the same address, a comparator reports the collision. An arbiter then gives that word to the port that arrived first and raises a busy flag toward the other port. A port's write is discarded while its busy flag is high. Reads are never blocked. The owning port keeps the word until the collision ends. A write from either port becomes visible to a later read from the other port. The block runs on one clock with a synchronous active-high reset.

Top module: `dpram_contend`

## Requirements
- R1: While reset is high and directly after it, both busy flags are 0 and both read data outputs are 0. Memory contents are not cleared.
- R2: Whenever both ports are enabled with equal addresses, exactly one busy flag is 1. Otherwise both busy flags are 0.
- R3: If one port was enabled on an address in the previous cycle and the other port arrives on that address now, the port that arrived later gets busy in the same cycle.
- R4: If neither port was on the shared address in the previous cycle, the right port gets busy and the left port keeps the word.
- R5: While the collision continues, the busy flag stays on the same port, even if the arrival order would now favour the other port.
- R6: Busy drops in the same cycle that the addresses differ or either port is disabled.
- R7: A write (enable=1, write select=1) from a port whose busy flag is high leaves the memory unchanged.
- R8: A write from a port that is not busy is stored at the clock edge where it is presented. A read of that address by either port in a later cycle returns the new value.
- R9: Read data is updated at a clock edge only when that port has enable=1, output enable=1 and write select=0. In every other case it holds its value.
- R10: Without a collision, both ports write and read any of the 1024 addresses independently in the same cycles, with read data appearing one clock after the read is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write select (1 = write, 0 = read) |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | 10 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port registered read data |
| l_busy | output | 1 | Left port lost the shared word; its writes are dropped |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write select (1 = write, 0 = read) |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | 10 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port registered read data |
| r_busy | output | 1 | Right port lost the shared word; its writes are dropped |

## Verification
The assertions assume that every port input changes only between clock edges and is settled when the edge arrives. This matters because busy is formed combinationally from the current addresses and enables, and the properties compare it with those inputs at the edge. The stimulus meets this assumption by driving all inputs on the falling edge. The stimulus never reads a location before that location has been written, because the memory is not initialised and its reset contents are not defined. Collisions are created on purpose to set the arrival order, and the sweeps are built so that their addresses never coincide.

// File: rtl/dpram_contend_pkg.sv
package dpram_contend_pkg;

    localparam int ADDR_W_DEF = 10;
    localparam int DATA_W_DEF = 8;
    localparam int NUM_PORTS  = 2;
    localparam int PORT_L     = 0;
    localparam int PORT_R     = 1;

    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;

    function automatic logic wants_read(input logic en, input logic we, input logic oe);
        return en & oe & ~we;
    endfunction

    function automatic logic wants_write(input logic en, input logic we);
        return en & we;
    endfunction

endpackage

// File: rtl/dpc_match.sv
module dpc_match #(
    parameter int ADDR_W = dpram_contend_pkg::ADDR_W_DEF
) (
    input  logic              en_a,
    input  logic              en_b,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same
);
    always_comb begin
        same = en_a && en_b && (addr_a == addr_b);
    end
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
    import dpram_contend_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_l,
    input  logic              en_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              clash,
    output logic              busy_l,
    output logic              busy_r
);
    holder_e             hold_q, hold_cur, fresh;
    logic                seen_l_q, seen_r_q;
    logic [ADDR_W-1:0]   last_l_q, last_r_q;
    logic                early_l, early_r;

    // a port was there first if it sat on the same address last cycle
    always_comb begin
        early_l = seen_l_q && (last_l_q == addr_l);
        early_r = seen_r_q && (last_r_q == addr_r);
        fresh   = (early_r && !early_l) ? HOLD_RIGHT : HOLD_LEFT;
        if (!clash)
            hold_cur = HOLD_NONE;
        else if (hold_q != HOLD_NONE)
            hold_cur = hold_q;
        else
            hold_cur = fresh;
        busy_l = (hold_cur == HOLD_RIGHT);
        busy_r = (hold_cur == HOLD_LEFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= HOLD_NONE;
            seen_l_q <= 1'b0;
            seen_r_q <= 1'b0;
            last_l_q <= '0;
            last_r_q <= '0;
        end else begin
            hold_q   <= hold_cur;
            seen_l_q <= en_l;
            seen_r_q <= en_r;
            last_l_q <= addr_l;
            last_r_q <= addr_r;
        end
    end

    // R2
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_l && busy_r));

    // R2
    clash_flags_one_chk: assert property (@(posedge clk) disable iff (rst)
        clash |-> (busy_l || busy_r));

    // R6
    busy_needs_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_l || busy_r) |-> (en_l && en_r && addr_l == addr_r));

    // R5
    keep_right_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_r |=> (!clash || busy_r));

    // R5
    keep_left_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_l |=> (!clash || busy_l));
endmodule

// File: rtl/dpc_array.sv
module dpc_array
    import dpram_contend_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_PORTS-1:0]               en,
    input  logic [NUM_PORTS-1:0]               we,
    input  logic [NUM_PORTS-1:0]               oe,
    input  logic [NUM_PORTS-1:0]               blocked,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]   wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0]    mem [DEPTH];
    logic [NUM_PORTS-1:0] commit;
    logic [NUM_PORTS-1:0] fetch;

    always_ff @(posedge clk) begin
        if (commit[PORT_L]) mem[addr[PORT_L]] <= wdata[PORT_L];
        if (commit[PORT_R]) mem[addr[PORT_R]] <= wdata[PORT_R];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_comb begin
            commit[p] = wants_write(en[p], we[p]) && !blocked[p];
            fetch[p]  = wants_read(en[p], we[p], oe[p]);
        end

        always_ff @(posedge clk) begin
            if (rst)
                rdata[p] <= '0;
            else if (fetch[p])
                rdata[p] <= mem[addr[p]];
        end

        // R9
        rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(en[p] && oe[p] && !we[p]) |=> $stable(rdata[p]));
    end

    // R7
    single_writer_chk: assert property (@(posedge clk) disable iff (rst)
        !(commit[PORT_L] && commit[PORT_R] && addr[PORT_L] == addr[PORT_R]));
endmodule

// File: rtl/dpram_contend.sv
module dpram_contend
    import dpram_contend_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_en,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy,
    input  logic              r_en,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy
);
    logic                               clash;
    logic [NUM_PORTS-1:0][DATA_W-1:0]   rd_bus;

    dpc_match #(.ADDR_W(ADDR_W)) u_match (
        .en_a   (l_en),
        .en_b   (r_en),
        .addr_a (l_addr),
        .addr_b (r_addr),
        .same   (clash)
    );

    dpc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .en_l   (l_en),
        .en_r   (r_en),
        .addr_l (l_addr),
        .addr_r (r_addr),
        .clash  (clash),
        .busy_l (l_busy),
        .busy_r (r_busy)
    );

    dpc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .en      ({r_en, l_en}),
        .we      ({r_we, l_we}),
        .oe      ({r_oe, l_oe}),
        .blocked ({r_busy, l_busy}),
        .addr    ({r_addr, l_addr}),
        .wdata   ({r_wdata, l_wdata}),
        .rdata   (rd_bus)
    );

    assign l_rdata = rd_bus[PORT_L];
    assign r_rdata = rd_bus[PORT_R];
endmodule

// File: tb/dpram_contend_bench.sv
module dpram_contend_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_en = 0, l_we = 0, l_oe = 0, r_en = 0, r_we = 0, r_oe = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_busy, r_busy;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_contend u_dpram_contend (
        .clk(clk), .rst(rst),
        .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy(l_busy),
        .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy(r_busy)
    );

    function automatic logic [DW-1:0] pat_a(input int a);
        return DW'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [DW-1:0] pat_b(input int a);
        return DW'(((a ^ (a >> 3)) & 255) ^ 8'h5A);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drv_l(input logic en, input logic we, input logic oe,
                         input int a, input logic [DW-1:0] d);
        l_en = en; l_we = we; l_oe = oe; l_addr = AW'(a); l_wdata = d;
    endtask

    task automatic drv_r(input logic en, input logic we, input logic oe,
                         input int a, input logic [DW-1:0] d);
        r_en = en; r_we = we; r_oe = oe; r_addr = AW'(a); r_wdata = d;
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while in reset
        chk("R1 busy during reset", {l_busy, r_busy}, 0);
        chk("R1 rdata during reset", {l_rdata, r_rdata}, 0);
        rst = 1'b0;
        settle();
        chk("R1 busy after reset", {l_busy, r_busy}, 0);
        tick();

        // R10: left fills, right reads back
        for (int a = 0; a < WORDS; a++) begin
            drv_l(1, 1, 0, a, pat_a(a)); drv_r(0, 0, 0, 0, 0);
            model[a] = pat_a(a);
            tick();
        end
        drv_l(0, 0, 0, 0, 0);
        for (int a = 0; a < WORDS; a++) begin
            drv_r(1, 0, 1, a, 0);
            tick();
            chk("R10 right reads left data", r_rdata, model[a]);
        end

        // R10: both ports write concurrently on mirrored addresses
        for (int a = 0; a < WORDS; a++) begin
            drv_l(1, 1, 0, a, pat_b(a));
            drv_r(1, 1, 0, WORDS - 1 - a, pat_a(a));
            settle();
            if (l_busy || r_busy) chk("R2 no busy without clash", {l_busy, r_busy}, 0);
            tick();
        end
        for (int x = 0; x < WORDS; x++)
            model[x] = (x >= WORDS / 2) ? pat_b(x) : pat_a(WORDS - 1 - x);
        for (int a = 0; a < WORDS; a++) begin
            drv_l(1, 0, 1, a, 0);
            drv_r(1, 0, 1, WORDS - 1 - a, 0);
            tick();
            chk("R10 left concurrent read", l_rdata, model[a]);
            chk("R10 right concurrent read", r_rdata, model[WORDS - 1 - a]);
        end

        // R3: left first on 100, right arrives later and tries to write
        drv_l(1, 0, 1, 100, 0); drv_r(1, 0, 1, 7, 0);
        tick();
        drv_r(1, 1, 0, 100, 8'hEE);
        settle();
        chk("R3 later right port busy", {l_busy, r_busy}, 2'b01);
        tick();
        drv_r(0, 0, 0, 0, 0);
        settle();
        chk("R6 busy drops with right disabled", {l_busy, r_busy}, 0);
        tick();
        chk("R7 blocked right write, left read", l_rdata, model[100]);

        // R3: right first on 200, left arrives later
        drv_l(0, 0, 0, 0, 0); drv_r(1, 0, 1, 200, 0);
        tick();
        drv_l(1, 1, 0, 200, 8'h11);
        settle();
        chk("R3 later left port busy", {l_busy, r_busy}, 2'b10);
        tick();
        drv_l(0, 0, 0, 0, 0); drv_r(1, 0, 1, 200, 0);
        tick();
        chk("R7 blocked left write", r_rdata, model[200]);

        // R4: simultaneous arrival on 300, both write
        drv_l(0, 0, 0, 0, 0); drv_r(0, 0, 0, 0, 0);
        tick();
        drv_l(1, 1, 0, 300, 8'hA1); drv_r(1, 1, 0, 300, 8'hB2);
        settle();
        chk("R4 tie favours left", {l_busy, r_busy}, 2'b01);
        model[300] = 8'hA1;
        tick();
        // R5: hold ownership while clash continues
        for (int k = 0; k < 4; k++) begin
            drv_l(1, 0, 1, 300, 0); drv_r(1, 1, 0, 300, 8'hC3);
            settle();
            chk("R5 owner kept", {l_busy, r_busy}, 2'b01);
            tick();
        end
        chk("R8 winner write visible on own read", l_rdata, 8'hA1);
        // R6: address change releases busy
        drv_r(1, 0, 1, 301, 0);
        settle();
        chk("R6 busy drops on address change", {l_busy, r_busy}, 0);
        tick();
        drv_r(1, 0, 1, 300, 0);
        settle();
        chk("R3 left stayed, right returns busy", {l_busy, r_busy}, 2'b01);
        tick();
        chk("R8 right reads left write", r_rdata, 8'hA1);
        drv_l(0, 0, 1, 300, 0);
        settle();
        chk("R6 busy drops on left disable", {l_busy, r_busy}, 0);
        tick();

        // R8: left writes 400 while right reads elsewhere, then right reads it
        drv_l(1, 1, 0, 400, 8'h3C); drv_r(1, 0, 1, 500, 0);
        model[400] = 8'h3C;
        tick();
        chk("R10 right reads 500", r_rdata, model[500]);
        drv_l(0, 0, 0, 0, 0); drv_r(1, 0, 1, 400, 0);
        tick();
        chk("R8 port-to-port data", r_rdata, 8'h3C);

        // R9: hold when not reading
        drv_r(1, 0, 0, 401, 0);
        tick();
        chk("R9 hold with output enable low", r_rdata, 8'h3C);
        drv_r(0, 0, 1, 402, 0);
        tick();
        chk("R9 hold with port disabled", r_rdata, 8'h3C);
        drv_r(1, 1, 1, 403, 8'h99);
        model[403] = 8'h99;
        tick();
        chk("R9 hold while writing", r_rdata, 8'h3C);
        drv_r(1, 0, 1, 403, 0);
        tick();
        chk("R8 right reads own write", r_rdata, 8'h99);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule